// File: doc/BRIEF.md
# Comparator Channel Control Register with Sticky Lock

This block is the digital side of one analog comparator channel. It holds a single 32-bit control word that software writes through a plain write strobe and reads back at any time. The fields of the word pick the comparator inputs, the hysteresis and the speed, and they set up the conditioning of the digital result. A software-settable lock bit freezes the whole word until the next reset.

The conditioning path takes the raw decision of this comparator and of a paired comparator. It can replace the local decision with the XOR of the two, which is used for window detection, and it can invert the result. Five timer strobes can blank the output, each one enabled by its own bit of a mask. The conditioned level drives an output pin and also appears as a read-only bit in the read word. The input selects are not used inside the block. They are decoded onto select outputs for the analog multiplexers, and any code the block does not support maps to a safe default.

Control word layout (bit positions):

| Bits | Field | Meaning |
|------|-------|---------|
| 0 | en | Channel enable |
| 4:1 | negSel | Inverting-input code, 0..8 valid |
| 6:5 | posSel | Non-inverting code, 3 = open |
| 7 | winIn | 1 = take the paired channel's non-inverting input |
| 8 | winOut | 0 = own result, 1 = own XOR paired |
| 9 | invert | Output polarity |
| 11:10 | hyst | Hysteresis code |
| 13:12 | pwr | 0 = high speed, 1 = medium speed |
| 18:14 | blankMask | Blanking source enables |
| 29:19 | — | Read as 0, not stored |
| 30 | status | Conditioned output, read-only |
| 31 | lock | Sticky lock |

Top module: `cmp_chan_reg`

## Requirements
- R1: After reset every field, including the lock, is 0. rdData reads 0 and condOut is 0.
- R2: While the lock is clear, a cycle with wrEn high stores wrData bits 31 and 18:0 at the clock edge. rdData shows the stored value from the next cycle on. Bits 29:19 and bit 30 of the write data are not stored, and bits 29:19 of rdData read 0.
- R3: Once bit 31 is stored as 1, every later write is ignored, including one that clears bit 31. rdData keeps returning the frozen contents until reset.
- R4: With winOut=0 the selected result is cmpOwn. With winOut=1 it is cmpOwn XOR cmpPair.
- R5: With invert=1 the selected result is inverted. With invert=0 it passes through unchanged.
- R6: If any bit set in blankMask has its blankIn strobe high in the same cycle, condOut is 0. Strobes whose mask bit is 0 have no effect.
- R7: With en=0, condOut and the status bit are 0 whatever the comparator and blanking inputs are.
- R8: rdData bit 30 always equals condOut, and condOut follows the inputs combinationally.
- R9: negSelOut equals negSel for codes 0..8 and is 0 for codes 9..15. pwrOut equals pwr for codes 0 and 1 and is 0 for codes 2 and 3. posSelOut, hystOut, posFromPair (winIn) and chanEn (en) show their fields directly. rdData still shows the raw stored codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read word: stored fields plus status in bit 30 |
| cmpOwn | input | 1 | Raw decision of this comparator |
| cmpPair | input | 1 | Raw decision of the paired comparator |
| blankIn | input | 5 | Timer blanking strobes |
| condOut | output | 1 | Conditioned comparator output |
| chanEn | output | 1 | Enable to the analog comparator |
| negSelOut | output | 4 | Decoded inverting-input select |
| posSelOut | output | 2 | Non-inverting-input select |
| posFromPair | output | 1 | Take the paired channel's non-inverting input |
| hystOut | output | 2 | Hysteresis select |
| pwrOut | output | 2 | Decoded power/speed select |

## Verification
The hardest case to reach is a locked word that receives writes. Its contents have to stay frozen even against a write that clears the lock bit, and a second reset must then make the word writable again. To reach it, the stimulus first sets up a known non-trivial configuration and sets the lock together with it. It then writes bursts of other values, including all-zeros and all-ones, and changes the comparator and blanking inputs, while the reference model checks the read word and the outputs on every cycle. After that it asserts reset in the middle of the run and checks that a fresh write is accepted.

// File: rtl/cmp_chan_pkg.sv
package cmp_chan_pkg;
  localparam int DATA_W  = 32;
  localparam int NEG_W   = 4;
  localparam int POS_W   = 2;
  localparam int HYST_W  = 2;
  localparam int PWR_W   = 2;
  localparam int BLANK_W = 5;
  localparam int NEG_MAX = 8;
  localparam int PWR_MAX = 1;

  localparam int EN_B     = 0;
  localparam int NEG_LO   = 1;
  localparam int POS_LO   = NEG_LO + NEG_W;
  localparam int WIN_IN_B = POS_LO + POS_W;
  localparam int WIN_OUT_B= WIN_IN_B + 1;
  localparam int INV_B    = WIN_OUT_B + 1;
  localparam int HYST_LO  = INV_B + 1;
  localparam int PWR_LO   = HYST_LO + HYST_W;
  localparam int BLANK_LO = PWR_LO + PWR_W;
  localparam int STAT_B   = DATA_W - 2;
  localparam int LOCK_B   = DATA_W - 1;

  typedef struct packed {
    logic               lock;
    logic [BLANK_W-1:0] blankMask;
    logic [PWR_W-1:0]   pwr;
    logic [HYST_W-1:0]  hyst;
    logic               invert;
    logic               winOut;
    logic               winIn;
    logic [POS_W-1:0]   posSel;
    logic [NEG_W-1:0]   negSel;
    logic               en;
  } cfg_t;

  function automatic cfg_t unpackCfg(input logic [DATA_W-1:0] w);
    cfg_t c;
    c.en        = w[EN_B];
    c.negSel    = w[NEG_LO +: NEG_W];
    c.posSel    = w[POS_LO +: POS_W];
    c.winIn     = w[WIN_IN_B];
    c.winOut    = w[WIN_OUT_B];
    c.invert    = w[INV_B];
    c.hyst      = w[HYST_LO +: HYST_W];
    c.pwr       = w[PWR_LO +: PWR_W];
    c.blankMask = w[BLANK_LO +: BLANK_W];
    c.lock      = w[LOCK_B];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] packCfg(input cfg_t c, input logic status);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_B]                 = c.en;
    w[NEG_LO +: NEG_W]      = c.negSel;
    w[POS_LO +: POS_W]      = c.posSel;
    w[WIN_IN_B]             = c.winIn;
    w[WIN_OUT_B]            = c.winOut;
    w[INV_B]                = c.invert;
    w[HYST_LO +: HYST_W]    = c.hyst;
    w[PWR_LO +: PWR_W]      = c.pwr;
    w[BLANK_LO +: BLANK_W]  = c.blankMask;
    w[STAT_B]               = status;
    w[LOCK_B]               = c.lock;
    return w;
  endfunction
endpackage

// File: rtl/cmp_chan_ctrl.sv
module cmp_chan_ctrl
  import cmp_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output cfg_t              cfg
);
  logic wrAccept;
  assign wrAccept = wrEn && !cfg.lock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfg <= '0;
    else if (wrAccept) cfg <= unpackCfg(wrData);
  end

  // R3: a locked word never changes, and the lock never clears by write
  a_r3_lock_freezes: assert property (@(posedge clk) disable iff (!rstN)
    cfg.lock |=> (cfg == $past(cfg)));
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfg.lock |=> cfg.lock);
  // R2: with no write strobe the word holds
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(cfg));
endmodule

// File: rtl/cmp_chan_dpath.sv
module cmp_chan_dpath
  import cmp_chan_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cfg_t               cfg,
  input  logic               cmpOwn,
  input  logic               cmpPair,
  input  logic [BLANK_W-1:0] blankIn,
  output logic               condOut,
  output logic [NEG_W-1:0]   negSelOut,
  output logic [PWR_W-1:0]   pwrOut
);
  logic [BLANK_W-1:0] blankHit;
  logic blankAny, selRes, polRes;

  for (genvar i = 0; i < BLANK_W; i++) begin : g_blank
    assign blankHit[i] = cfg.blankMask[i] & blankIn[i];
  end
  assign blankAny = |blankHit;

  always_comb begin
    selRes  = cfg.winOut ? (cmpOwn ^ cmpPair) : cmpOwn;
    polRes  = selRes ^ cfg.invert;
    condOut = cfg.en & ~blankAny & polRes;
  end

  assign negSelOut = (cfg.negSel > NEG_W'(NEG_MAX)) ? '0 : cfg.negSel;
  assign pwrOut    = (cfg.pwr > PWR_W'(PWR_MAX)) ? '0 : cfg.pwr;

  // R7: disabled channel stays low
  a_r7_off_low: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.en |-> !condOut);
  // R6: an enabled active strobe blanks the output
  a_r6_blank_low: assert property (@(posedge clk) disable iff (!rstN)
    (|(cfg.blankMask & blankIn)) |-> !condOut);
  // R9: decoded selects never leave the supported range
  a_r9_neg_safe: assert property (@(posedge clk) disable iff (!rstN)
    negSelOut <= NEG_W'(NEG_MAX));
  a_r9_pwr_safe: assert property (@(posedge clk) disable iff (!rstN)
    pwrOut <= PWR_W'(PWR_MAX));
endmodule

// File: rtl/cmp_chan_reg.sv
module cmp_chan_reg
  import cmp_chan_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic               cmpOwn,
  input  logic               cmpPair,
  input  logic [BLANK_W-1:0] blankIn,
  output logic               condOut,
  output logic               chanEn,
  output logic [NEG_W-1:0]   negSelOut,
  output logic [POS_W-1:0]   posSelOut,
  output logic               posFromPair,
  output logic [HYST_W-1:0]  hystOut,
  output logic [PWR_W-1:0]   pwrOut
);
  cfg_t cfg;

  cmp_chan_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .cfg(cfg)
  );

  cmp_chan_dpath i_dpath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .cmpOwn(cmpOwn), .cmpPair(cmpPair),
    .blankIn(blankIn), .condOut(condOut), .negSelOut(negSelOut), .pwrOut(pwrOut)
  );

  assign rdData      = packCfg(cfg, condOut);
  assign chanEn      = cfg.en;
  assign posSelOut   = cfg.posSel;
  assign posFromPair = cfg.winIn;
  assign hystOut     = cfg.hyst;

  // R8: status bit mirrors the conditioned output
  a_r8_status_mirror: assert property (@(posedge clk) disable iff (!rstN)
    rdData[STAT_B] == condOut);
endmodule

// File: tb/test_cmp_chan_reg.sv
module test_cmp_chan_reg;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic [31:0] wrData = 0;
  logic [31:0] rdData;
  logic        cmpOwn = 0, cmpPair = 0;
  logic [4:0]  blankIn = 0;
  logic        condOut, chanEn, posFromPair;
  logic [3:0]  negSelOut;
  logic [1:0]  posSelOut, hystOut, pwrOut;

  int checks = 0, errors = 0, cycles = 0;
  bit checking = 0;
  string phase = "R1";
  logic [31:0] regM = 0;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  cmp_chan_reg i_cmp_chan_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .cmpOwn(cmpOwn), .cmpPair(cmpPair), .blankIn(blankIn), .condOut(condOut),
    .chanEn(chanEn), .negSelOut(negSelOut), .posSelOut(posSelOut),
    .posFromPair(posFromPair), .hystOut(hystOut), .pwrOut(pwrOut)
  );

  // behavioural register model: stored bits are 31 and 18:0
  always @(posedge clk or negedge rstN) begin
    if (!rstN) regM <= 0;
    else if (wrEn && !regM[31]) regM <= wrData & 32'h8007_FFFF;
  end

  function automatic bit expCond();
    bit sel, blank;
    sel   = regM[8] ? (cmpOwn ^ cmpPair) : cmpOwn;
    sel   = sel ^ regM[9];
    blank = |(regM[18:14] & blankIn);
    return regM[0] && !blank && sel;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      bit c;
      logic [3:0] n;
      logic [1:0] p;
      c = expCond();
      chk(phase, {31'b0, condOut}, {31'b0, c});
      chk("R2", rdData & 32'hBFFF_FFFF, regM);
      chk("R8", {31'b0, rdData[30]}, {31'b0, c});
      n = (regM[4:1] > 8) ? 4'd0 : regM[4:1];
      p = (regM[13:12] > 1) ? 2'd0 : regM[13:12];
      chk("R9", {22'b0, negSelOut, posSelOut, posFromPair, hystOut, pwrOut, chanEn},
                {22'b0, n, regM[6:5], regM[7], regM[11:10], p, regM[0]});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input bit w, input logic [31:0] d, input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      wrEn = w; wrData = d;
      seed = seed * 1103515245 + 12345;
      cmpOwn = seed[16]; cmpPair = seed[19]; blankIn = seed[24:20];
    end
    @(posedge clk); #2; wrEn = 0;
  endtask

  task automatic inputs(input bit o, input bit p, input logic [4:0] b);
    @(posedge clk); #2; wrEn = 0; cmpOwn = o; cmpPair = p; blankIn = b;
  endtask

  initial begin
    #23 rstN = 1;
    #4;
    phase = "R1";
    chk("R1", rdData, 32'h0);
    chk("R1", {31'b0, condOut}, 32'h0);
    checking = 1;
    // R4: own result only, then XOR of pair
    phase = "R4";
    cyc(1, 32'h0000_0001, 1);
    for (int i = 0; i < 4; i++) inputs(i[0], i[1], 0);
    cyc(1, 32'h0000_0101, 1);
    for (int i = 0; i < 4; i++) inputs(i[0], i[1], 0);
    // R5: polarity
    phase = "R5";
    cyc(1, 32'h0000_0201, 1);
    for (int i = 0; i < 4; i++) inputs(i[0], i[1], 0);
    cyc(1, 32'h0000_0301, 1);
    for (int i = 0; i < 4; i++) inputs(i[0], i[1], 0);
    // R6: each blank source with its mask bit set, and with the mask clear
    phase = "R6";
    cyc(1, 32'h0000_4201 | (32'h1F << 14), 1);
    for (int i = 0; i < 5; i++) inputs(0, 0, 5'(1 << i));
    cyc(1, 32'h0000_0201 | (32'h05 << 14), 1);
    for (int i = 0; i < 32; i++) inputs(0, 0, 5'(i));
    // R7: disabled channel
    phase = "R7";
    cyc(1, 32'h0000_0200, 1);
    for (int i = 0; i < 4; i++) inputs(i[0], i[1], 0);
    // R9: select decodes, all codes
    phase = "R9";
    for (int n = 0; n < 16; n++)
      cyc(1, 32'(n << 1) | 32'((n & 3) << 12) | 32'((n & 3) << 5) | 32'((n & 3) << 10) | 32'((n & 1) << 7), 1);
    // R2: random writes, status and unused bits in write data ignored
    phase = "R2";
    for (int i = 0; i < 200; i++) begin
      seed = seed * 1103515245 + 12345;
      cyc(1, (seed ^ (seed << 7)) & 32'h7FFF_FFFF, 1);
      cyc(0, 0, 2);
    end
    // R3: lock with a known word, then attempt overwrites
    phase = "R3";
    cyc(1, 32'h8001_52A3 | 32'h4000_0000, 1);
    cyc(1, 32'h0000_0000, 3);
    cyc(1, 32'hFFFF_FFFF, 3);
    cyc(1, 32'h0000_0101, 50);
    chk("R3", rdData & 32'hBFFF_FFFF, 32'h8001_52A3);
    // reset clears the lock, writes accepted again
    @(posedge clk); #2; rstN = 0;
    #10 rstN = 1;
    #2;
    chk("R1", rdData, 32'h0);
    phase = "R3";
    cyc(1, 32'h0000_0001, 1);
    #1 chk("R3", rdData & 32'hBFFF_FFFF, 32'h0000_0001);
    cyc(0, 0, 20);
    checking = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule